// File: doc/BRIEF.md
# Chip-Select Gated Registered Fanout Buffer

This block registers a 28-bit command and address word on each rising clock edge and drives every registered bit onto two identical output ports, so one source can feed two banks of loads. It sits between a memory controller and the devices on a module, adding one clock of latency.

To save switching power, the register stops updating when the gate-enable input and both active-low chip-select inputs are high at a clock edge: no rank is addressed, so the outputs keep their previous value. If the gate-enable input is tied low, the gating is switched off and the register updates on every clock. An asynchronous active-low reset clears the register at once and forces both output ports low. Reset takes priority over the gating.

Top module: `csg_fanout_buf`

## Requirements
- R1: On every rising clock edge that is not gated, the register captures `din`, and both output ports show that value until the next update. This is one clock of latency.
- R2: `qa` and `qb` carry the same value at all times.
- R3: Driving `rst_n` low clears the register and drives `qa` and `qb` to all zeros at once, without waiting for a clock edge.
- R4: While `rst_n` is low, both outputs stay at zero whatever the clock, data, gate-enable and chip-select inputs do. Reset overrides the gating.
- R5: At a rising edge where `gate_en`, `cs0_n` and `cs1_n` are all 1, the register holds and both outputs keep their previous value.
- R6: At a rising edge where `gate_en` is 1 and at least one of `cs0_n` or `cs1_n` is 0, the register captures `din` as in R1.
- R7: At a rising edge where `gate_en` is 0, the register captures `din` whatever the chip-select levels are.
- R8: After `rst_n` rises, the outputs stay at zero until the first ungated rising edge captures data. The first ungated edge after a run of gated edges presents the data sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1 lets the chip-selects gate the register, 0 disables gating |
| cs0_n | input | 1 | Rank 0 select, active low |
| cs1_n | input | 1 | Rank 1 select, active low |
| din | input | 28 | Command and address word to register |
| qa | output | 28 | Registered copy A |
| qb | output | 28 | Registered copy B |

## Verification
The properties assume that `gate_en`, `cs0_n`, `cs1_n` and `din` are stable around each rising edge. The stimulus meets this by changing these inputs only on the falling clock edge. The properties also assume that a reset window is never shorter than the time it takes the disable condition to take effect. For this reason the bench asserts `rst_n` mid-cycle and holds it low across at least one clock edge, and it releases `rst_n` only on a falling edge. The gated-hold and update properties look one cycle back, and they are disabled during reset, so an asynchronous reset between two edges never compares against a value taken before it.

// File: rtl/csg_fanout_pkg.sv
package csg_fanout_pkg;
  typedef enum logic {
    CAP_UPDATE = 1'b0,
    CAP_HOLD   = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/csg_gate_ctl.sv
module csg_gate_ctl
  import csg_fanout_pkg::*;
#(
  parameter int N_SEL = 2
) (
  input  logic             gate_en,
  input  logic [N_SEL-1:0] sel_n,
  output cap_mode_e        mode
);
  // Gating is armed only when gate_en is high and no select line is asserted
  always_comb begin
    if (gate_en && (&sel_n)) mode = CAP_HOLD;
    else                     mode = CAP_UPDATE;
  end
endmodule

// File: rtl/csg_capture_reg.sv
module csg_capture_reg
  import csg_fanout_pkg::*;
#(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cap_mode_e        mode,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= '0;
    else if (mode == CAP_UPDATE) q <= d;
  end

  // R4
  always @(posedge clk) begin
    if (!rst_n) rst_clear_chk: assert (q == '0);
  end

  // R5
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_HOLD) |=> $stable(q));
endmodule

// File: rtl/csg_fanout_drv.sv
module csg_fanout_drv #(
  parameter int WIDTH  = 28,
  parameter int COPIES = 2
) (
  input  logic                          clk,
  input  logic [WIDTH-1:0]              q,
  output logic [COPIES-1:0][WIDTH-1:0]  qout
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    assign qout[c] = q;
    if (c > 0) begin : g_cmp
      // R2
      always @(negedge clk) copy_match_chk: assert (qout[c] == qout[0]);
    end
  end
endmodule

// File: rtl/csg_fanout_buf.sv
module csg_fanout_buf
  import csg_fanout_pkg::*;
#(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             cs0_n,
  input  logic             cs1_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] qa,
  output logic [WIDTH-1:0] qb
);
  localparam int N_SEL  = 2;
  localparam int COPIES = 2;

  cap_mode_e                        mode;
  logic [WIDTH-1:0]                 q_reg;
  logic [COPIES-1:0][WIDTH-1:0]     fan;

  csg_gate_ctl #(.N_SEL(N_SEL)) u_ctl (
    .gate_en (gate_en),
    .sel_n   ({cs1_n, cs0_n}),
    .mode    (mode)
  );

  csg_capture_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .d     (din),
    .q     (q_reg)
  );

  csg_fanout_drv #(.WIDTH(WIDTH), .COPIES(COPIES)) u_fan (
    .clk  (clk),
    .q    (q_reg),
    .qout (fan)
  );

  assign qa = fan[0];
  assign qb = fan[1];

  // R6
  sel_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !(cs0_n && cs1_n)) |=> (qa == $past(din)));

  // R7
  ungated_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en) |=> (qb == $past(din)));

  // R5
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && cs0_n && cs1_n) |=> $stable(qa));
endmodule

// File: tb/tb_csg_fanout_buf.sv
module tb_csg_fanout_buf;
  localparam int W = 28;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gate_en = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] qa, qb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [W-1:0] val;
    string        rid;
  } exp_t;
  exp_t         sb[$];
  logic [W-1:0] model = '0;

  always #5 clk = ~clk;

  csg_fanout_buf #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs0_n(cs0_n),
    .cs1_n(cs1_n), .din(din), .qa(qa), .qb(qb)
  );

  task automatic chk(input string rid, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rid, act, exp);
    end
  endtask

  // Driver: applies inputs on the falling edge and predicts the next output
  task automatic drive(input logic [W-1:0] d, input logic ge, input logic c0,
                       input logic c1, input string rid);
    exp_t it;
    @(negedge clk);
    din = d; gate_en = ge; cs0_n = c0; cs1_n = c1;
    if (!(ge && c0 && c1)) model = d;
    it.val = model;
    it.rid = rid;
    sb.push_back(it);
  endtask

  // Monitor: compares both ports shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk({it.rid, " qa"}, qa, it.val);
        chk({it.rid, " qb (R2)"}, qb, it.val);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R4: reset held with busy, ungated inputs
    din = 28'hABCDEF1; gate_en = 1'b0; cs0_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 chk("R4 reset qa", qa, '0);
    chk("R4 reset qb", qb, '0);
    // R8: release, outputs low before first edge
    @(negedge clk); din = 28'h1234567; rst_n = 1'b1;
    #1 chk("R8 after release", qa, '0);
    // R1 basic capture, several patterns
    drive(28'h1234567, 1'b0, 1'b1, 1'b1, "R1");
    drive(28'hFFFFFFF, 1'b0, 1'b1, 1'b1, "R7 ungated cs high");
    drive(28'h5555555, 1'b0, 1'b0, 1'b0, "R7 ungated cs low");
    drive(28'hAAAAAAA, 1'b1, 1'b0, 1'b1, "R6 cs0 low");
    drive(28'h0F0F0F0, 1'b1, 1'b1, 1'b0, "R6 cs1 low");
    drive(28'h3C3C3C3, 1'b1, 1'b0, 1'b0, "R6 both low");
    // R5 gated hold across several edges with changing data
    drive(28'h0000001, 1'b1, 1'b1, 1'b1, "R5 hold");
    drive(28'h7777777, 1'b1, 1'b1, 1'b1, "R5 hold");
    drive(28'h8888888, 1'b1, 1'b1, 1'b1, "R5 hold");
    // R8 first ungated edge presents fresh data
    drive(28'h9ABCDEF, 1'b1, 1'b0, 1'b1, "R8 ungate fresh");
    drive(28'h0000000, 1'b0, 1'b0, 1'b1, "R1 zeros");
    drive(28'hDEADBEE, 1'b1, 1'b1, 1'b0, "R1");
    @(negedge clk); @(negedge clk);
    // R3: async reset mid-cycle, gated so no edge would change anything
    gate_en = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1; din = 28'h1111111;
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1 chk("R3 async clear qa", qa, '0);
    chk("R3 async clear qb", qb, '0);
    // R4 reset beats ungated selection
    gate_en = 1'b0; cs0_n = 1'b0; din = 28'h2222222;
    @(posedge clk); #2 chk("R4 priority", qa, '0);
    // R8 release while gated: outputs remain zero
    @(negedge clk); gate_en = 1'b1; cs0_n = 1'b1; rst_n = 1'b1;
    model = '0;
    drive(28'h4444444, 1'b1, 1'b1, 1'b1, "R8 gated after reset");
    drive(28'h6666666, 1'b1, 1'b1, 1'b0, "R8 first capture");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule